// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is a small single-accumulator processor driven by a timing-step sequencer. Its register set is an address register, a program counter, a data register, an instruction register and an accumulator with a carry flag. Instructions and data share one memory reached over one bus. That bus carries an address, read data, write data, a read strobe and a write strobe. Every instruction runs as a fixed series of numbered steps. A step counter clears back to the first step when an instruction finishes.

A 16-bit instruction word holds the opcode in bits 14..12 and the operand address in bits 11..0; bit 15 has no meaning and is ignored. The eight opcodes are: bitwise AND into the accumulator, add into the accumulator, load, store, unconditional jump, jump that saves a return address, increment memory with skip-if-zero, and halt. The block also has a single-level interrupt. When interrupts are enabled and a request is pending as an instruction ends, the block stores the program counter at address 0, continues at address 1 and disables further interrupts.

The memory is outside the block. It must return `mem_rdata` for `mem_addr` within the same cycle, and it writes `mem_wdata` at the clock edge that ends a cycle with `mem_we` high.

Top module: `acc_seq_cpu`

## Requirements
- R1: A synchronous reset clears the accumulator, program counter, carry, interrupt enable and halt state, and returns the sequencer to step 0. Reset has priority over every other input.
- R2: Fetch takes three steps. In step 0 the address register takes the program counter. In step 1 the word at that address is read into the instruction register and the program counter increments. In step 2 the opcode (bits 14..12) is decoded and the address register takes bits 11..0. Bit 15 is ignored.
- R3: The read strobe and the write strobe are never high in the same cycle.
- R4: Opcodes 0 (AND), 1 (ADD) and 2 (load) read the operand and update the accumulator, each in 5 steps. ADD sets the carry to the carry-out of the 16-bit sum. AND and load leave the carry unchanged.
- R5: Opcode 3 writes the accumulator to the addressed word, in 4 steps.
- R6: Opcode 4 loads the program counter with the operand address, in 4 steps.
- R7: Opcode 5 writes the address of the next instruction into the addressed word and continues at that address plus one, in 5 steps.
- R8: Opcode 6 writes back the addressed word plus one (modulo 2^16) and skips the next instruction when the result is zero, in 6 steps.
- R9: Opcode 7 halts the block 3 steps after its fetch begins. The halted block holds the program counter at the halt word's address plus one and makes no further memory access until reset.
- R10: When an instruction other than halt ends with interrupts enabled and `irq_req` high, the block runs a 2-step interrupt cycle before the next fetch. The cycle writes the program counter to address 0, sets the program counter to 1 and clears the interrupt enable. With interrupts disabled, `irq_req` has no effect.
- R11: `ien_arm` high at a clock edge outside reset sets the interrupt enable. Clearing by an interrupt cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ien_arm | input | 1 | Sets the interrupt enable |
| irq_req | input | 1 | Pending interrupt request (level) |
| mem_rdata | input | 16 | Word read from memory at `mem_addr`, valid in the same cycle |
| mem_addr | output | 12 | Memory address, driven by the address register |
| mem_wdata | output | 16 | Word to write |
| mem_we | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| carry_out | output | 1 | Carry flag |
| ien_out | output | 1 | Interrupt enable |
| halted | output | 1 | Halt state |

## Verification
The bench observes only the ports. A wrong step count or a mis-sequenced step is therefore detected as a shifted cycle count to halt, or as a wrong program counter, accumulator or memory word once the program stops, at most a few dozen cycles after the fault. Bad skip, return-address or interrupt-vector logic corrupts the program counter, so execution goes down a different path and the final program counter and memory words reveal it. Bus contention shows in the same cycle as the read and write strobes being high together.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_AND = 3'd0,
    OPC_ADD = 3'd1,
    OPC_LDA = 3'd2,
    OPC_STA = 3'd3,
    OPC_JMP = 3'd4,
    OPC_JSV = 3'd5,
    OPC_INZ = 3'd6,
    OPC_HLT = 3'd7
  } opcode_e;
endpackage

// File: rtl/acc_step_ctr.sv
module acc_step_ctr #(
  parameter int STEP_W = 3,
  parameter int LAST   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst)      step_q <= '0;
    else if (clr) step_q <= '0;
    else if (adv) step_q <= step_q + 1'b1;
  end

  assign step = step_q;

  // R2: the sequence never runs past the longest instruction
  assert_step_range_R2: assert property (@(posedge clk) disable iff (rst)
    step_q <= STEP_W'(LAST));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_e      op,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] dr,
  input  logic         c_in,
  output logic [W-1:0] y,
  output logic         c_out,
  output logic [W-1:0] dr_inc
);
  function automatic logic [W:0] add_w(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [W-1:0] inc_w(input logic [W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [W:0] sum;
  assign sum    = add_w(ac, dr);
  assign dr_inc = inc_w(dr);

  always_comb begin
    y     = ac;
    c_out = c_in;
    case (op)
      OPC_AND: y = ac & dr;
      OPC_ADD: begin y = sum[W-1:0]; c_out = sum[W]; end
      OPC_LDA: y = dr;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int VEC_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ien_arm,
  input  logic              irq_req,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_rd,
  output logic [WORD_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              carry_out,
  output logic              ien_out,
  output logic              halted
);
  localparam int IR_W      = ADDR_W + OPC_W;
  localparam int STEP_W    = 3;
  localparam int LAST_STEP = 5;

  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [WORD_W-1:0] dr_q, ac_q;
  logic [IR_W-1:0]   ir_q;
  logic              e_q, ien_q, halt_q, icyc_q;
  logic [STEP_W-1:0] step;
  opcode_e           opc;

  assign opc = opcode_e'(ir_q[ADDR_W +: OPC_W]);

  // named internal events
  logic active, fetch_ld, decode, ex3, ex4, ex5;
  logic op_reads, is_read, wr_sta, wr_jsv, wr_inz, wr_int;
  logic instr_end, int_end, take_int, seq_clr;

  assign active   = !halt_q;
  assign fetch_ld = !icyc_q && step == STEP_W'(1);
  assign decode   = !icyc_q && step == STEP_W'(2);
  assign ex3      = !icyc_q && step == STEP_W'(3);
  assign ex4      = !icyc_q && step == STEP_W'(4);
  assign ex5      = !icyc_q && step == STEP_W'(5);
  assign op_reads = opc == OPC_AND || opc == OPC_ADD || opc == OPC_LDA || opc == OPC_INZ;
  assign is_read  = fetch_ld || (ex3 && op_reads);
  assign wr_sta   = ex3 && opc == OPC_STA;
  assign wr_jsv   = ex3 && opc == OPC_JSV;
  assign wr_inz   = ex5 && opc == OPC_INZ;
  assign wr_int   = icyc_q && step == STEP_W'(1);

  assign instr_end = (decode && opc == OPC_HLT)
                  || (ex3 && (opc == OPC_STA || opc == OPC_JMP))
                  || (ex4 && (opc == OPC_AND || opc == OPC_ADD || opc == OPC_LDA || opc == OPC_JSV))
                  || (ex5 && opc == OPC_INZ);
  assign int_end  = wr_int;
  assign take_int = instr_end && opc != OPC_HLT && ien_q && irq_req;
  assign seq_clr  = instr_end || int_end;

  acc_step_ctr #(.STEP_W(STEP_W), .LAST(LAST_STEP)) u_step (
    .clk (clk),
    .rst (rst),
    .clr (seq_clr),
    .adv (active),
    .step(step)
  );

  logic [WORD_W-1:0] alu_y, dr_inc;
  logic              alu_c;

  acc_alu #(.W(WORD_W)) u_alu (
    .op    (opc),
    .ac    (ac_q),
    .dr    (dr_q),
    .c_in  (e_q),
    .y     (alu_y),
    .c_out (alu_c),
    .dr_inc(dr_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q   <= '0;
      pc_q   <= '0;
      dr_q   <= '0;
      ir_q   <= '0;
      ac_q   <= '0;
      e_q    <= 1'b0;
      halt_q <= 1'b0;
      icyc_q <= 1'b0;
    end else if (active) begin
      if (icyc_q) begin
        if (step == STEP_W'(0)) ar_q <= ADDR_W'(VEC_ADDR);
        if (wr_int) begin
          pc_q   <= ADDR_W'(VEC_ADDR + 1);
          icyc_q <= 1'b0;
        end
      end else begin
        case (step)
          STEP_W'(0): ar_q <= pc_q;
          STEP_W'(1): begin
            ir_q <= mem_rdata[IR_W-1:0];
            pc_q <= pc_q + 1'b1;
          end
          STEP_W'(2): begin
            ar_q <= ir_q[ADDR_W-1:0];
            if (opc == OPC_HLT) halt_q <= 1'b1;
          end
          STEP_W'(3): begin
            if (op_reads)        dr_q <= mem_rdata;
            if (opc == OPC_JMP)  pc_q <= ar_q;
            if (opc == OPC_JSV)  ar_q <= ar_q + 1'b1;
          end
          STEP_W'(4): begin
            if (opc == OPC_AND || opc == OPC_ADD || opc == OPC_LDA) begin
              ac_q <= alu_y;
              e_q  <= alu_c;
            end
            if (opc == OPC_JSV) pc_q <= ar_q;
            if (opc == OPC_INZ) dr_q <= dr_inc;
          end
          STEP_W'(5): begin
            if (opc == OPC_INZ && dr_q == '0) pc_q <= pc_q + 1'b1;
          end
          default: ;
        endcase
        if (take_int) icyc_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    ien_q <= 1'b0;
    else if (active && int_end) ien_q <= 1'b0;
    else if (ien_arm)           ien_q <= 1'b1;
  end

  assign mem_addr  = ar_q;
  assign mem_rd    = active && is_read;
  assign mem_we    = active && (wr_sta || wr_jsv || wr_inz || wr_int);
  assign mem_wdata = wr_sta ? ac_q : (wr_inz ? dr_q : WORD_W'(pc_q));

  assign acc_out   = ac_q;
  assign pc_out    = pc_q;
  assign carry_out = e_q;
  assign ien_out   = ien_q;
  assign halted    = halt_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc_q == '0 && ac_q == '0 && !e_q && !ien_q && !halt_q && step == '0));

  assert_bus_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_rd));

  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_ld && active) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (!mem_we && !mem_rd));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && $stable(pc_q) && $stable(ac_q)));

  assert_int_vector_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_int && active) |-> (mem_we && mem_addr == ADDR_W'(VEC_ADDR)));

  assert_int_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_int && active) |=> (pc_q == ADDR_W'(VEC_ADDR + 1) && !ien_q && step == '0));
endmodule

// File: tb/acc_seq_cpu_test.sv
`timescale 1ns/1ps
module acc_seq_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ien_arm = 1'b0;
  logic        irq_req = 1'b0;
  logic [15:0] mem_rdata, mem_wdata, acc_out;
  logic [11:0] mem_addr, pc_out;
  logic        mem_we, mem_rd, carry_out, ien_out, halted;

  logic [15:0] mem [4096];
  logic [15:0] mm  [4096];

  int n_chk = 0;
  int n_fail = 0;
  int clash = 0;

  always #10 clk = ~clk;

  acc_seq_cpu uut (
    .clk(clk), .rst(rst), .ien_arm(ien_arm), .irq_req(irq_req),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rd(mem_rd), .acc_out(acc_out), .pc_out(pc_out),
    .carry_out(carry_out), .ien_out(ien_out), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  always @(negedge clk) if (!rst && mem_we && mem_rd) clash++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int a, input bit b15 = 1'b0);
    logic [2:0]  o = op[2:0];
    logic [11:0] ad = a[11:0];
    return {b15, o, ad};
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w;
    mm[a]  = w;
  endtask

  task automatic wipe();
    @(negedge clk);
    rst = 1'b1; ien_arm = 1'b0; irq_req = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; mm[i] = '0; end
  endtask

  task automatic go(output int n);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      ien_arm = 1'b0;
    end
  endtask

  // instruction-level reference: steps, final pc, accumulator, carry
  task automatic model(output int steps, output logic [11:0] pc,
                       output logic [15:0] ac, output logic e);
    logic [15:0] w;
    logic [11:0] a;
    logic [16:0] s;
    bit done;
    steps = 0; pc = '0; ac = '0; e = 1'b0; done = 1'b0;
    for (int k = 0; k < 1000 && !done; k++) begin
      w = mm[pc]; a = w[11:0]; pc = pc + 12'd1; steps += 3;
      case (w[14:12])
        3'd0: begin ac = ac & mm[a]; steps += 2; end
        3'd1: begin s = {1'b0, ac} + {1'b0, mm[a]}; ac = s[15:0]; e = s[16]; steps += 2; end
        3'd2: begin ac = mm[a]; steps += 2; end
        3'd3: begin mm[a] = ac; steps += 1; end
        3'd4: begin pc = a; steps += 1; end
        3'd5: begin mm[a] = {4'd0, pc}; pc = a + 12'd1; steps += 2; end
        3'd6: begin mm[a] = mm[a] + 16'd1; if (mm[a] == 16'd0) pc = pc + 12'd1; steps += 3; end
        default: done = 1'b1;
      endcase
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, msteps, bad;
    logic [11:0] mpc;
    logic [15:0] mac, w0;
    logic me;
    void'($urandom(32'd24601));

    // R1: reset state
    wipe();
    chk("R1 acc after reset", acc_out, 0);
    chk("R1 pc after reset", pc_out, 0);
    chk("R1 carry/ien/halt after reset", {carry_out, ien_out, halted}, 0);
    chk("R1 no write during reset", mem_we, 0);

    // R1 mid-run reset, R4 load
    put(0, ins(2, 12'h030)); put(1, ins(7, 0)); put(12'h030, 16'hC3C3);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 load before reset", acc_out, 16'hC3C3);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 acc cleared by reset", acc_out, 0);
    chk("R1 pc cleared by reset", pc_out, 0);

    // R9: lone halt
    wipe();
    put(0, ins(7, 12'h123));
    go(n);
    chk("R9 halt cycles", n, 3);
    chk("R9 halt pc", pc_out, 1);
    repeat (5) @(negedge clk);
    chk("R9 halted holds", {halted, pc_out}, {1'b1, 12'd1});

    // R4 carry behaviour
    wipe();
    put(0, ins(2, 12'h030)); put(1, ins(1, 12'h031)); put(2, ins(0, 12'h032));
    put(3, ins(7, 0));
    put(12'h030, 16'hFFFF); put(12'h031, 16'h0002); put(12'h032, 16'h00FF);
    go(n);
    chk("R4 add then and result", acc_out, 16'h0001);
    chk("R4 carry kept through AND", carry_out, 1);
    chk("R4 cycles", n, 18);

    // R5 R6: store and jump
    wipe();
    put(0, ins(2, 12'h030)); put(1, ins(4, 12'h020)); put(2, ins(7, 0));
    put(12'h020, ins(3, 12'h031)); put(12'h021, ins(7, 0)); put(12'h030, 16'h5A5A);
    go(n);
    chk("R5 stored word", mem[12'h031], 16'h5A5A);
    chk("R6 jump final pc", pc_out, 12'h022);
    chk("R5 R6 cycles", n, 16);

    // R7: save return address
    wipe();
    put(0, ins(5, 12'h050)); put(12'h051, ins(2, 12'h060)); put(12'h052, ins(7, 0));
    put(12'h060, 16'h1234);
    go(n);
    chk("R7 return address saved", mem[12'h050], 16'h0001);
    chk("R7 continued at target+1", acc_out, 16'h1234);
    chk("R7 final pc", pc_out, 12'h053);
    chk("R7 cycles", n, 13);

    // R8 skip; R10 request ignored while disabled
    wipe();
    put(0, ins(6, 12'h040)); put(1, ins(2, 12'h041)); put(2, ins(7, 0));
    put(12'h040, 16'hFFFF); put(12'h041, 16'hABCD);
    irq_req = 1'b1;
    go(n);
    chk("R8 wrapped to zero", mem[12'h040], 16'h0000);
    chk("R8 skip taken acc", acc_out, 16'h0000);
    chk("R8 skip pc", pc_out, 12'h003);
    chk("R8 skip cycles", n, 9);
    chk("R10 no vector store while disabled", mem[0], ins(6, 12'h040));

    // R8 no skip
    wipe();
    put(0, ins(6, 12'h040)); put(1, ins(2, 12'h041)); put(2, ins(7, 0));
    put(12'h040, 16'h0005); put(12'h041, 16'hABCD);
    go(n);
    chk("R8 incremented", mem[12'h040], 16'h0006);
    chk("R8 no skip acc", acc_out, 16'hABCD);
    chk("R8 no skip cycles", n, 14);

    // R11: arm sets enable
    wipe();
    put(0, ins(7, 0));
    ien_arm = 1'b1;
    go(n);
    chk("R11 enable set", ien_out, 1);

    // R10: interrupt cycle
    wipe();
    put(0, ins(4, 12'h100)); put(1, ins(4, 12'h200));
    put(12'h100, ins(7, 0)); put(12'h200, ins(7, 0));
    ien_arm = 1'b1; irq_req = 1'b1;
    go(n);
    chk("R10 pc stored at vector", mem[0], 16'h0100);
    chk("R10 handler reached", pc_out, 12'h201);
    chk("R10 enable cleared", ien_out, 0);
    chk("R10 cycles", n, 13);

    // R2 R4 R5 R8 random programs, bit 15 random, request with enable off
    for (int r = 0; r < 24; r++) begin
      wipe();
      for (int i = 0; i < 16; i++)
        put(12'h080 + i, ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom));
      for (int i = 0; i < 10; i++) begin
        int sel = $urandom_range(0, 4);
        int op = (sel == 4) ? 6 : sel;
        put(i, ins(op, 12'h080 + $urandom_range(0, 15), 1'($urandom)));
      end
      put(10, ins(7, 0)); put(11, ins(7, 0));
      irq_req = 1'($urandom);
      model(msteps, mpc, mac, me);
      go(n);
      chk("R4 random acc", acc_out, mac);
      chk("R4 random carry", carry_out, me);
      chk("R2 random final pc", pc_out, mpc);
      chk("R9 random cycles", n, msteps);
      bad = 0;
      for (int i = 0; i < 16; i++) if (mem[12'h080 + i] !== mm[12'h080 + i]) bad++;
      chk("R5 R8 random data words", bad, 0);
      w0 = mem[0];
      chk("R10 random vector untouched", w0, mm[0]);
    end

    chk("R3 read and write never together", clash, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule